// File: doc/BRIEF.md
# Trace Value Predictor Table

This block predicts how a trace of instructions will end before it runs. A trace is identified by the program counter (PC) of its first instruction. A direct-mapped table, indexed by that PC, keeps three things for each trace: where the trace last ended, a short history of the values each live-output register took at the end of the trace, and stride and confidence state for each of those registers. A lookup returns, one cycle later, a hit flag, the predicted end PC and one predicted value per live-output lane. Each lane chooses between a stride prediction and a context prediction. The context prediction finds the last value earlier in the history and proposes the value that followed it there.

When a trace completes, the caller reports its start PC, its end PC and the values it produced on the update port. A tag mismatch at that index replaces the entry. A match trains the entry.

A separate detector watches the retired instruction stream and reports where traces begin and end. A trace ends at a backward branch, but only once it has reached a minimum length. A trace that reaches the maximum length is cut there, whether or not a branch has been seen.

Top module: `trace_value_predictor`

## Requirements
- R1: A lookup presented with `lk_valid` high returns its result on the next cycle, with `pr_valid` high. `pr_valid` is low on the cycle after a cycle with no lookup. While `pr_hit` is low, `pr_end_pc`, `pr_vals` and `pr_ctx_sel` are all zero.
- R2: The entry index is the low log2(ENTRIES) bits of the PC, and the tag is the remaining upper bits. A lookup hits only when the entry is valid and its stored tag equals the PC's upper bits.
- R3: An update whose PC misses (entry invalid or tag different) rewrites the tag and stores the end PC. For each lane it sets the newest history slot to the reported value, clears the older slots, clears the stride and clears the confidence.
- R4: An update whose PC hits replaces the end PC. For each lane it sets the stride to the new value minus the previous newest value (modulo 2^VAL_W) and shifts the new value into the history, newest first.
- R5: When a lane's confidence is below its maximum (3, a 2-bit counter), the predicted value is the newest history value plus the stride, modulo 2^VAL_W. In this case the lane's bit of `pr_ctx_sel` is 0.
- R6: The context prediction searches history slots 1 up to HIST_DEPTH-1, nearest slot first, for the newest value. If it finds it in slot j, the prediction is slot j-1; if not, the prediction is the newest value. On a hitting update, confidence increments (saturating) if the context prediction equalled the new value and clears otherwise. At saturation the context prediction is used and the lane's bit of `pr_ctx_sel` (lane g at bit g) is 1.
- R7: A lookup in the same cycle as an update to the same entry returns the prediction from before that update.
- R8: After reset no entry is valid, so every lookup misses.
- R9: A retired instruction is a backward branch when `ret_is_br` is high and `ret_target` is at most `ret_pc` (unsigned). Such an instruction closes the trace when the trace length, counting this instruction, is at least MIN_LEN.
- R10: A backward branch that arrives while the trace is shorter than MIN_LEN does not close the trace. The trace continues to a later boundary.
- R11: A trace that reaches MAX_LEN instructions closes at that instruction, whether or not it is a branch.
- R12: A closed trace is reported the cycle after its last instruction retires, with `bnd_valid` high for one cycle. `bnd_start_pc` is the PC of the first instruction retired after the previous close (or after reset), `bnd_end_pc` is the PC of the closing instruction, and `bnd_len` is the instruction count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_pc | input | PC_W | Trace start PC to look up |
| upd_valid | input | 1 | Update request |
| upd_pc | input | PC_W | Start PC of the completed trace |
| upd_end_pc | input | PC_W | Observed end PC |
| upd_vals | input | NUM_LIVE*VAL_W | Observed live-output values, lane g at bits g*VAL_W and up |
| pr_valid | output | 1 | Lookup result valid |
| pr_hit | output | 1 | Lookup hit |
| pr_end_pc | output | PC_W | Predicted end PC |
| pr_vals | output | NUM_LIVE*VAL_W | Predicted live-output values |
| pr_ctx_sel | output | NUM_LIVE | Per lane: 1 when the context prediction was used |
| ret_valid | input | 1 | An instruction retired |
| ret_pc | input | PC_W | PC of the retired instruction |
| ret_is_br | input | 1 | Retired instruction is a taken branch |
| ret_target | input | PC_W | Branch target |
| bnd_valid | output | 1 | A trace closed |
| bnd_start_pc | output | PC_W | First PC of the closed trace |
| bnd_end_pc | output | PC_W | Last PC of the closed trace |
| bnd_len | output | $clog2(MAX_LEN+1) | Instruction count of the closed trace |

## Verification
The bench builds the block with ENTRIES set to 4 and every other parameter at its default: 16-bit PCs and values, two lanes, a history depth of 9, and a length window of 8 to 64. Because there are only four entries, the random PCs from 0 to 15 alias onto each other all the time, so tag replacement and the tag comparison are exercised heavily. Each PC's lane 0 follows a period-3 pattern, which drives the confidence counter to saturation and exercises the switch to the context prediction. Its lane 1 follows a steady stride. The retire stream mixes short and long runs, so both the branch-closed traces and the traces cut at 64 instructions occur.

// File: rtl/tvp_pkg.sv
package tvp_pkg;
    localparam int unsigned CONF_W = 2;
    typedef logic [CONF_W-1:0] conf_t;
    localparam conf_t CONF_MAX = '1;
endpackage

// File: rtl/tvp_ctx.sv
// Context prediction for one lane: find the newest value further back in
// the history and propose the value that followed it.
module tvp_ctx #(
    parameter int unsigned VAL_W      = 16,
    parameter int unsigned HIST_DEPTH = 9
) (
    input  logic [VAL_W-1:0] hist_i [HIST_DEPTH],
    output logic [VAL_W-1:0] ctx_o
);
    logic found;

    always_comb begin
        ctx_o = hist_i[0];
        found = 1'b0;
        for (int j = 1; j < HIST_DEPTH; j++) begin
            if (!found && hist_i[j] == hist_i[0]) begin
                ctx_o = hist_i[j-1];
                found = 1'b1;
            end
        end
    end
endmodule

// File: rtl/tvp_lane_upd.sv
// Next-state of one lane of an entry on update (training or allocation).
module tvp_lane_upd
    import tvp_pkg::*;
#(
    parameter int unsigned VAL_W      = 16,
    parameter int unsigned HIST_DEPTH = 9
) (
    input  logic             hit_i,
    input  logic [VAL_W-1:0] hist_i [HIST_DEPTH],
    input  conf_t            conf_i,
    input  logic [VAL_W-1:0] ctx_i,
    input  logic [VAL_W-1:0] new_i,
    output logic [VAL_W-1:0] hist_o [HIST_DEPTH],
    output logic [VAL_W-1:0] stride_o,
    output conf_t            conf_o
);
    always_comb begin
        hist_o[0] = new_i;
        for (int k = 1; k < HIST_DEPTH; k++) begin
            hist_o[k] = hit_i ? hist_i[k-1] : '0;
        end
        if (hit_i) begin
            stride_o = new_i - hist_i[0];
            if (ctx_i == new_i) begin
                conf_o = (conf_i == CONF_MAX) ? conf_i : conf_i + conf_t'(1);
            end else begin
                conf_o = '0;
            end
        end else begin
            stride_o = '0;
            conf_o   = '0;
        end
    end
endmodule

// File: rtl/tvp_boundary.sv
// Trace boundary detection from the retired instruction stream.
module tvp_boundary #(
    parameter int unsigned PC_W    = 16,
    parameter int unsigned MIN_LEN = 8,
    parameter int unsigned MAX_LEN = 64,
    localparam int unsigned LEN_W  = $clog2(MAX_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ret_valid,
    input  logic [PC_W-1:0]  ret_pc,
    input  logic             ret_is_br,
    input  logic [PC_W-1:0]  ret_target,
    output logic             bnd_valid,
    output logic [PC_W-1:0]  bnd_start_pc,
    output logic [PC_W-1:0]  bnd_end_pc,
    output logic [LEN_W-1:0] bnd_len
);
    typedef struct packed {
        logic [LEN_W-1:0] cnt;
        logic [PC_W-1:0]  start_pc;
        logic             out_valid;
        logic [PC_W-1:0]  out_start;
        logic [PC_W-1:0]  out_end;
        logic [LEN_W-1:0] out_len;
    } bstate_t;

    bstate_t st_d, st_q;
    logic [LEN_W-1:0] cnt_n;
    logic [PC_W-1:0]  cur_start;
    logic             backward;

    always_comb begin
        st_d           = st_q;
        st_d.out_valid = 1'b0;
        cnt_n          = st_q.cnt + LEN_W'(1);
        cur_start      = (st_q.cnt == '0) ? ret_pc : st_q.start_pc;
        backward       = ret_is_br && (ret_target <= ret_pc);
        if (ret_valid) begin
            if ((backward && cnt_n >= LEN_W'(MIN_LEN)) || cnt_n == LEN_W'(MAX_LEN)) begin
                st_d.out_valid = 1'b1;
                st_d.out_start = cur_start;
                st_d.out_end   = ret_pc;
                st_d.out_len   = cnt_n;
                st_d.cnt       = '0;
            end else begin
                st_d.cnt      = cnt_n;
                st_d.start_pc = cur_start;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bnd_valid    = st_q.out_valid;
    assign bnd_start_pc = st_q.out_start;
    assign bnd_end_pc   = st_q.out_end;
    assign bnd_len      = st_q.out_len;
endmodule

// File: rtl/trace_value_predictor.sv
module trace_value_predictor
    import tvp_pkg::*;
#(
    parameter int unsigned PC_W       = 16,
    parameter int unsigned VAL_W      = 16,
    parameter int unsigned NUM_LIVE   = 2,
    parameter int unsigned ENTRIES    = 8,
    parameter int unsigned HIST_DEPTH = 9,
    parameter int unsigned MIN_LEN    = 8,
    parameter int unsigned MAX_LEN    = 64,
    localparam int unsigned IDX_W     = $clog2(ENTRIES),
    localparam int unsigned TAG_W     = PC_W - IDX_W,
    localparam int unsigned LEN_W     = $clog2(MAX_LEN + 1),
    localparam int unsigned VEC_W     = NUM_LIVE * VAL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_valid,
    input  logic [PC_W-1:0]  lk_pc,
    input  logic             upd_valid,
    input  logic [PC_W-1:0]  upd_pc,
    input  logic [PC_W-1:0]  upd_end_pc,
    input  logic [VEC_W-1:0] upd_vals,
    output logic             pr_valid,
    output logic             pr_hit,
    output logic [PC_W-1:0]  pr_end_pc,
    output logic [VEC_W-1:0] pr_vals,
    output logic [NUM_LIVE-1:0] pr_ctx_sel,
    input  logic             ret_valid,
    input  logic [PC_W-1:0]  ret_pc,
    input  logic             ret_is_br,
    input  logic [PC_W-1:0]  ret_target,
    output logic             bnd_valid,
    output logic [PC_W-1:0]  bnd_start_pc,
    output logic [PC_W-1:0]  bnd_end_pc,
    output logic [LEN_W-1:0] bnd_len
);
    typedef struct packed {
        logic                valid;
        logic                hit;
        logic [PC_W-1:0]     end_pc;
        logic [VEC_W-1:0]    vals;
        logic [NUM_LIVE-1:0] sel;
    } pred_t;

    // table state
    logic             vld_d    [ENTRIES];
    logic             vld_q    [ENTRIES];
    logic [TAG_W-1:0] tag_d    [ENTRIES];
    logic [TAG_W-1:0] tag_q    [ENTRIES];
    logic [PC_W-1:0]  endpc_d  [ENTRIES];
    logic [PC_W-1:0]  endpc_q  [ENTRIES];
    logic [VAL_W-1:0] hist_d   [ENTRIES][NUM_LIVE][HIST_DEPTH];
    logic [VAL_W-1:0] hist_q   [ENTRIES][NUM_LIVE][HIST_DEPTH];
    logic [VAL_W-1:0] stride_d [ENTRIES][NUM_LIVE];
    logic [VAL_W-1:0] stride_q [ENTRIES][NUM_LIVE];
    conf_t            conf_d   [ENTRIES][NUM_LIVE];
    conf_t            conf_q   [ENTRIES][NUM_LIVE];

    pred_t pred_d, pred_q;

    logic [IDX_W-1:0] lk_idx, up_idx;
    logic [TAG_W-1:0] lk_tag, up_tag;
    logic             lk_hit, up_hit;

    // per-lane views of the two addressed entries
    logic [VAL_W-1:0] lk_hist  [NUM_LIVE][HIST_DEPTH];
    logic [VAL_W-1:0] up_hist  [NUM_LIVE][HIST_DEPTH];
    logic [VAL_W-1:0] lk_ctx   [NUM_LIVE];
    logic [VAL_W-1:0] up_ctx   [NUM_LIVE];
    logic [VAL_W-1:0] nx_hist  [NUM_LIVE][HIST_DEPTH];
    logic [VAL_W-1:0] nx_stride[NUM_LIVE];
    conf_t            nx_conf  [NUM_LIVE];

    assign lk_idx = lk_pc[IDX_W-1:0];
    assign lk_tag = lk_pc[PC_W-1:IDX_W];
    assign up_idx = upd_pc[IDX_W-1:0];
    assign up_tag = upd_pc[PC_W-1:IDX_W];
    assign lk_hit = vld_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
    assign up_hit = vld_q[up_idx] && (tag_q[up_idx] == up_tag);

    always_comb begin
        for (int g = 0; g < NUM_LIVE; g++) begin
            for (int k = 0; k < HIST_DEPTH; k++) begin
                lk_hist[g][k] = hist_q[lk_idx][g][k];
                up_hist[g][k] = hist_q[up_idx][g][k];
            end
        end
    end

    for (genvar g = 0; g < NUM_LIVE; g++) begin : g_lane
        tvp_ctx #(.VAL_W(VAL_W), .HIST_DEPTH(HIST_DEPTH)) u_lk_ctx (
            .hist_i (lk_hist[g]),
            .ctx_o  (lk_ctx[g])
        );
        tvp_ctx #(.VAL_W(VAL_W), .HIST_DEPTH(HIST_DEPTH)) u_up_ctx (
            .hist_i (up_hist[g]),
            .ctx_o  (up_ctx[g])
        );
        tvp_lane_upd #(.VAL_W(VAL_W), .HIST_DEPTH(HIST_DEPTH)) u_upd (
            .hit_i    (up_hit),
            .hist_i   (up_hist[g]),
            .conf_i   (conf_q[up_idx][g]),
            .ctx_i    (up_ctx[g]),
            .new_i    (upd_vals[g*VAL_W +: VAL_W]),
            .hist_o   (nx_hist[g]),
            .stride_o (nx_stride[g]),
            .conf_o   (nx_conf[g])
        );
    end

    // lookup result, read from the state before this cycle's update
    always_comb begin
        pred_d       = '0;
        pred_d.valid = lk_valid;
        if (lk_valid && lk_hit) begin
            pred_d.hit    = 1'b1;
            pred_d.end_pc = endpc_q[lk_idx];
            for (int g = 0; g < NUM_LIVE; g++) begin
                if (conf_q[lk_idx][g] == CONF_MAX) begin
                    pred_d.sel[g]               = 1'b1;
                    pred_d.vals[g*VAL_W +: VAL_W] = lk_ctx[g];
                end else begin
                    pred_d.vals[g*VAL_W +: VAL_W] =
                        lk_hist[g][0] + stride_q[lk_idx][g];
                end
            end
        end
    end

    // table next state
    always_comb begin
        vld_d    = vld_q;
        tag_d    = tag_q;
        endpc_d  = endpc_q;
        hist_d   = hist_q;
        stride_d = stride_q;
        conf_d   = conf_q;
        if (upd_valid) begin
            vld_d[up_idx]   = 1'b1;
            tag_d[up_idx]   = up_tag;
            endpc_d[up_idx] = upd_end_pc;
            for (int g = 0; g < NUM_LIVE; g++) begin
                for (int k = 0; k < HIST_DEPTH; k++) begin
                    hist_d[up_idx][g][k] = nx_hist[g][k];
                end
                stride_d[up_idx][g] = nx_stride[g];
                conf_d[up_idx][g]   = nx_conf[g];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pred_q <= '0;
            for (int e = 0; e < ENTRIES; e++) begin
                vld_q[e]   <= 1'b0;
                tag_q[e]   <= '0;
                endpc_q[e] <= '0;
                for (int g = 0; g < NUM_LIVE; g++) begin
                    stride_q[e][g] <= '0;
                    conf_q[e][g]   <= '0;
                    for (int k = 0; k < HIST_DEPTH; k++) begin
                        hist_q[e][g][k] <= '0;
                    end
                end
            end
        end else begin
            pred_q   <= pred_d;
            vld_q    <= vld_d;
            tag_q    <= tag_d;
            endpc_q  <= endpc_d;
            hist_q   <= hist_d;
            stride_q <= stride_d;
            conf_q   <= conf_d;
        end
    end

    assign pr_valid   = pred_q.valid;
    assign pr_hit     = pred_q.hit;
    assign pr_end_pc  = pred_q.end_pc;
    assign pr_vals    = pred_q.vals;
    assign pr_ctx_sel = pred_q.sel;

    tvp_boundary #(.PC_W(PC_W), .MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN)) u_bnd (
        .clk          (clk),
        .rst_n        (rst_n),
        .ret_valid    (ret_valid),
        .ret_pc       (ret_pc),
        .ret_is_br    (ret_is_br),
        .ret_target   (ret_target),
        .bnd_valid    (bnd_valid),
        .bnd_start_pc (bnd_start_pc),
        .bnd_end_pc   (bnd_end_pc),
        .bnd_len      (bnd_len)
    );
endmodule

// File: rtl/tvp_checker.sv
module tvp_checker #(
    parameter int unsigned PC_W     = 16,
    parameter int unsigned VEC_W    = 32,
    parameter int unsigned NUM_LIVE = 2,
    parameter int unsigned MIN_LEN  = 8,
    parameter int unsigned MAX_LEN  = 64,
    parameter int unsigned LEN_W    = 7
) (
    input logic                clk,
    input logic                rst_n,
    input logic                lk_valid,
    input logic                pr_valid,
    input logic                pr_hit,
    input logic [PC_W-1:0]     pr_end_pc,
    input logic [VEC_W-1:0]    pr_vals,
    input logic [NUM_LIVE-1:0] pr_ctx_sel,
    input logic                ret_valid,
    input logic                bnd_valid,
    input logic [LEN_W-1:0]    bnd_len
);
    p_lookup_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> pr_valid);

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !pr_valid);

    p_miss_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !pr_hit |-> (pr_end_pc == '0 && pr_vals == '0 && pr_ctx_sel == '0));

    p_hit_needs_lookup_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pr_hit |-> pr_valid);

    p_len_window_r11: assert property (@(posedge clk) disable iff (!rst_n)
        bnd_valid |-> (bnd_len >= LEN_W'(MIN_LEN) && bnd_len <= LEN_W'(MAX_LEN)));

    p_close_after_retire_r12: assert property (@(posedge clk) disable iff (!rst_n)
        bnd_valid |-> $past(ret_valid));

    p_close_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
        bnd_valid |=> (!bnd_valid || $past(ret_valid)));
endmodule

bind trace_value_predictor tvp_checker #(
    .PC_W(PC_W), .VEC_W(VEC_W), .NUM_LIVE(NUM_LIVE),
    .MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN), .LEN_W(LEN_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .lk_valid   (lk_valid),
    .pr_valid   (pr_valid),
    .pr_hit     (pr_hit),
    .pr_end_pc  (pr_end_pc),
    .pr_vals    (pr_vals),
    .pr_ctx_sel (pr_ctx_sel),
    .ret_valid  (ret_valid),
    .bnd_valid  (bnd_valid),
    .bnd_len    (bnd_len)
);

// File: tb/trace_value_predictor_test.sv
`timescale 1ns/1ps
module trace_value_predictor_test;
    localparam int PW = 16, VW = 16, NL = 2, E = 4, HD = 9, MINL = 8, MAXL = 64;
    localparam int LW = $clog2(MAXL + 1);
    localparam int IW = $clog2(E);

    logic clk = 0, rst_n = 0;
    always #4 clk = ~clk;

    logic lk_valid = 0, upd_valid = 0, ret_valid = 0, ret_is_br = 0;
    logic [PW-1:0] lk_pc = 0, upd_pc = 0, upd_end_pc = 0, ret_pc = 0, ret_target = 0;
    logic [NL*VW-1:0] upd_vals = 0;
    logic pr_valid, pr_hit, bnd_valid;
    logic [PW-1:0] pr_end_pc, bnd_start_pc, bnd_end_pc;
    logic [NL*VW-1:0] pr_vals;
    logic [NL-1:0] pr_ctx_sel;
    logic [LW-1:0] bnd_len;

    trace_value_predictor #(.PC_W(PW), .VAL_W(VW), .NUM_LIVE(NL), .ENTRIES(E),
        .HIST_DEPTH(HD), .MIN_LEN(MINL), .MAX_LEN(MAXL)) uut (.*);

    int checks = 0, fails = 0;
    bit done = 0;

    // reference model
    bit            m_vld [E];
    int unsigned   m_tag [E];
    logic [PW-1:0] m_end [E];
    logic [VW-1:0] m_hist [E][NL][HD];
    logic [VW-1:0] m_str [E][NL];
    int            m_conf [E][NL];
    int            b_cnt = 0;
    logic [PW-1:0] b_start = 0;
    int            gcnt [16];

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [VW-1:0] m_ctx(int e, int g);
        logic [VW-1:0] r = m_hist[e][g][0];
        for (int j = HD - 1; j >= 1; j--)
            if (m_hist[e][g][j] == m_hist[e][g][0]) r = m_hist[e][g][j-1];
        return r;
    endfunction

    function automatic void m_reset();
        for (int e = 0; e < E; e++) begin
            m_vld[e] = 0; m_tag[e] = 0; m_end[e] = 0;
            for (int g = 0; g < NL; g++) begin
                m_str[e][g] = 0; m_conf[e][g] = 0;
                for (int k = 0; k < HD; k++) m_hist[e][g][k] = 0;
            end
        end
    endfunction

    function automatic void m_update(logic [PW-1:0] pc, logic [PW-1:0] ep, logic [NL*VW-1:0] v);
        int e = int'(pc) % E;
        int unsigned t = int'(pc) >> IW;
        bit hit = m_vld[e] && m_tag[e] == t;
        for (int g = 0; g < NL; g++) begin
            logic [VW-1:0] nv = v[g*VW +: VW];
            if (hit) begin
                if (m_ctx(e, g) == nv) m_conf[e][g] = (m_conf[e][g] == 3) ? 3 : m_conf[e][g] + 1;
                else m_conf[e][g] = 0;
                m_str[e][g] = nv - m_hist[e][g][0];
                for (int k = HD - 1; k >= 1; k--) m_hist[e][g][k] = m_hist[e][g][k-1];
            end else begin
                m_conf[e][g] = 0; m_str[e][g] = 0;
                for (int k = 1; k < HD; k++) m_hist[e][g][k] = 0;
            end
            m_hist[e][g][0] = nv;
        end
        m_vld[e] = 1; m_tag[e] = t; m_end[e] = ep;
    endfunction

    // one cycle: drive at negedge, compute expectations, check after the edge
    task automatic step(bit lv, logic [PW-1:0] lp, bit uv, logic [PW-1:0] up,
                        logic [PW-1:0] ue, logic [NL*VW-1:0] uvals,
                        bit rv, logic [PW-1:0] rp, bit rb, logic [PW-1:0] rt);
        bit x_hit; logic [PW-1:0] x_end; logic [NL*VW-1:0] x_vals; logic [NL-1:0] x_sel;
        bit x_bv; logic [PW-1:0] x_bs, x_be; int x_bl; string btag;
        int e = int'(lp) % E;
        lk_valid = lv; lk_pc = lp; upd_valid = uv; upd_pc = up; upd_end_pc = ue; upd_vals = uvals;
        ret_valid = rv; ret_pc = rp; ret_is_br = rb; ret_target = rt;
        x_hit = lv && m_vld[e] && m_tag[e] == (int'(lp) >> IW);
        x_end = 0; x_vals = 0; x_sel = 0;
        if (x_hit) begin
            x_end = m_end[e];
            for (int g = 0; g < NL; g++) begin
                if (m_conf[e][g] == 3) begin x_sel[g] = 1; x_vals[g*VW +: VW] = m_ctx(e, g); end
                else x_vals[g*VW +: VW] = m_hist[e][g][0] + m_str[e][g];
            end
        end
        x_bv = 0; x_bs = 0; x_be = 0; x_bl = 0; btag = "R12";
        if (rv) begin
            int cn = b_cnt + 1;
            logic [PW-1:0] st = (b_cnt == 0) ? rp : b_start;
            bit back = rb && rt <= rp;
            if ((back && cn >= MINL) || cn == MAXL) begin
                x_bv = 1; x_bs = st; x_be = rp; x_bl = cn; b_cnt = 0;
                btag = (back && cn >= MINL) ? "R9" : "R11";
            end else begin
                b_cnt = cn; b_start = st;
                if (back) btag = "R10";
            end
        end
        if (uv) m_update(up, ue, uvals);
        @(posedge clk); #2;
        chk("R1 pr_valid", pr_valid, lv);
        chk("R2 pr_hit", pr_hit, x_hit);
        chk("R3 pr_end_pc", pr_end_pc, x_end);
        chk("R6 pr_ctx_sel", pr_ctx_sel, x_sel);
        chk((x_sel != 0) ? "R6 pr_vals" : "R5 pr_vals", pr_vals, x_vals);
        chk(btag, bnd_valid, x_bv);
        if (x_bv) begin
            chk("R12 start", bnd_start_pc, x_bs);
            chk("R12 end", bnd_end_pc, x_be);
            chk("R12 len", bnd_len, x_bl);
        end
        @(negedge clk);
    endtask

    function automatic logic [NL*VW-1:0] pack(logic [VW-1:0] a, logic [VW-1:0] b);
        return {b, a};
    endfunction

    initial begin
        int seed = 1234;
        logic [PW-1:0] rpc;
        void'($urandom(seed));
        m_reset();
        repeat (3) @(negedge clk);
        chk("R8 reset pr_valid", pr_valid, 0);
        chk("R8 reset bnd_valid", bnd_valid, 0);
        rst_n = 1;
        // R8: empty table misses
        step(1, 5, 0, 0, 0, 0, 0, 0, 0, 0);
        chk("R8 miss after reset", pr_hit, 0);
        // R3: allocation
        step(0, 0, 1, 5, 40, pack(100, 200), 0, 0, 0, 0);
        step(1, 5, 0, 0, 0, 0, 0, 0, 0, 0);
        chk("R3 alloc value", pr_vals, pack(100, 200));
        // R4/R5: stride training
        step(0, 0, 1, 5, 44, pack(110, 190), 0, 0, 0, 0);
        step(1, 5, 0, 0, 0, 0, 0, 0, 0, 0);
        chk("R4 stride value", pr_vals, pack(120, 180));
        chk("R4 end pc", pr_end_pc, 44);
        // R7: same-cycle lookup and update see the old entry
        step(1, 5, 1, 5, 50, pack(500, 600), 0, 0, 0, 0);
        chk("R7 old value", pr_vals, pack(120, 180));
        // R2: alias with a different tag misses, then replaces
        step(1, 5 + E, 0, 0, 0, 0, 0, 0, 0, 0);
        chk("R2 alias miss", pr_hit, 0);
        step(0, 0, 1, 5 + E, 60, pack(1, 2), 0, 0, 0, 0);
        step(1, 5, 0, 0, 0, 0, 0, 0, 0, 0);
        chk("R3 tag rewritten", pr_hit, 0);
        // R6: period-3 pattern saturates confidence
        for (int i = 0; i < 12; i++)
            step(0, 0, 1, 9, 70, pack((i % 3 == 0) ? 7 : (i % 3 == 1) ? 3 : 11, 16'(i)), 0, 0, 0, 0);
        step(1, 9, 0, 0, 0, 0, 0, 0, 0, 0);
        chk("R6 ctx engaged", pr_ctx_sel[0], 1);
        chk("R6 ctx value", pr_vals[VW-1:0], 7);
        // R10 then R9: short backward branch ignored, later one closes
        for (int i = 0; i < 10; i++)
            step(0, 0, 0, 0, 0, 0, 1, 16'(300 + i), (i == 4 || i == 9), 16'(290));
        chk("R9 closed len", bnd_len, 10);
        // R11: long straight run cut at the maximum
        for (int i = 0; i < MAXL; i++)
            step(0, 0, 0, 0, 0, 0, 1, 16'(400 + i), 0, 0);
        chk("R11 cut len", bnd_len, MAXL);
        chk("R11 cut end", bnd_end_pc, 16'(400 + MAXL - 1));
        // random mix
        rpc = 1000;
        for (int n = 0; n < 4000; n++) begin
            int p = $urandom % 16, q = $urandom % 16;
            bit rb = ($urandom % 6) == 0;
            logic [PW-1:0] rt = ($urandom % 2) ? rpc - 16'($urandom % 20) : rpc + 16'(1 + $urandom % 20);
            logic [VW-1:0] v0 = 16'((gcnt[q] % 3) * 37 + q);
            logic [VW-1:0] v1 = 16'(gcnt[q] * 5 + q * 3);
            if ($urandom % 8 == 0) v0 = 16'($urandom);
            gcnt[q]++;
            step($urandom % 2, 16'(p), $urandom % 2, 16'(q), 16'(q + 50), pack(v0, v1),
                 $urandom % 4 != 0, rpc, rb, rt);
            rpc = rb ? rt : rpc + 1;
            if (rpc < 100 || rpc > 60000) rpc = 1000;
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule